// File: doc/BRIEF.md
# Speculative Instruction Prefetch Controller

This controller sits between an instruction cache and a memory bus that supports bursts. When the cache reports an instruction miss, the controller issues a single-line demand fill for the missing line. It also probes the tag store for up to three following sequential lines, all in the same cycle. The run of absent lines that starts right after the missed line becomes one burst request. That burst goes out in the cycle that follows the demand handshake. Each line is four 64-bit beats long. Every beat received is passed to the cache data array together with its line address and beat index. A completed line is announced on a strobe that carries the line address.

A branch redirect can arrive while a speculative line is still filling. In that case a programmable beat-count threshold sets the outcome. If fewer beats of the line have arrived than the threshold, the burst is abandoned: the bus sees an abort pulse and a demand fill for the branch target in the same cycle. Otherwise the line is allowed to finish. A redirect that is not acted on at once is held as pending. Each time a line finishes, the pending redirect is checked again, and the line boundary counts as zero beats received. The demand line itself is never cut, and a line that was cut is never reported as complete.

Top module: `ipf_ctrl`

## Requirements
- R1: On the cycle a miss is accepted, probe lane i (i = 0..2) presents line address miss_addr+1+i, and probe_hit[i] = 1 means that line is already cached. The number of speculative lines is the count of consecutive absent lanes starting at lane 0, limited to cfg_depth.
- R2: If cfg_depth is 0, or the run of absent lines is 0, only the demand request is issued. Lanes at or beyond cfg_depth never add to the run.
- R3: The demand request has bus_req_spec=0, length 1 and the missed address. If there are speculative lines, the burst request (bus_req_spec=1, address miss_addr+1, length equal to the run) is presented in the cycle right after the demand handshake.
- R4: After the fourth beat of a line, line_done_valid pulses for one cycle in the following cycle with that line's address. Lines are reported in fill order.
- R5: A redirect during a speculative line with fewer beats received than cfg_thresh (the beat of the same cycle counts) abandons the burst. In the next cycle, bus_abort pulses together with a single-line demand request for the target with no prefetch, and the cut line is never reported.
- R6: A redirect during a speculative line with received beats at least cfg_thresh lets that line finish.
- R7: When a line completes, a pending redirect is checked again as if zero beats had been received. If cfg_thresh is above 0 and more speculative lines remain, the burst is cut at that point. After the last line completes, the target is requested without an abort. A cfg_thresh of 0 never cuts.
- R8: A redirect that arrives before or during the demand line never aborts the demand fill. It stays pending.
- R9: A miss presented while the controller is busy is ignored. A redirect presented while it is idle is ignored.
- R10: Every accepted beat drives fill_we=1, the address of the line being filled, the beat index within that line, and the beat data, all in the same cycle.
- R11: After reset there are no requests, no abort, no fill writes and no line completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth | input | 2 | Number of lines to prefetch, 0..3 |
| cfg_thresh | input | 3 | Beats that must be received to keep a speculative line, 0..4 |
| miss_valid | input | 1 | Instruction miss request |
| miss_addr | input | LA_W | Line address of the miss |
| probe_addr | output | 3*LA_W | Probe line addresses, lane i in bits i*LA_W upward |
| probe_hit | input | 3 | Tag presence for each probe lane |
| redirect_valid | input | 1 | Branch redirect |
| redirect_addr | input | LA_W | Line address of the branch target |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus accepts the request |
| bus_req_addr | output | LA_W | First line address of the request |
| bus_req_len | output | 2 | Number of lines in the request |
| bus_req_spec | output | 1 | Request is the speculative burst |
| bus_abort | output | 1 | Abandon the speculative burst in flight |
| beat_valid | input | 1 | Read data beat from the bus |
| beat_data | input | DW | Beat data |
| fill_we | output | 1 | Cache data array write strobe |
| fill_line | output | LA_W | Line address being written |
| fill_idx | output | 2 | Beat index within the line |
| fill_data | output | DW | Data written |
| line_done_valid | output | 1 | Line completed, mark valid |
| line_done_addr | output | LA_W | Address of the completed line |

## Verification
If the beat counter or the line index is wrong, the fault shows up one cycle after the fourth beat. Either line_done_valid fires with the wrong address, or it fires when it should not. It also appears on fill_idx and fill_line during every beat. A faulty abandon decision shows up in the cycle after the redirect or after the line boundary, as a missing or extra abort and target request. A wrong probe run length shows up as a wrong burst length in the cycle after the demand handshake.

// File: rtl/ipf_pkg.sv
package ipf_pkg;

    localparam int IPF_LINE_BEATS = 4;
    localparam int IPF_MAX_LINES  = 3;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DREQ = 2'd1,
        S_SREQ = 2'd2,
        S_FILL = 2'd3
    } ipf_state_e;

    typedef enum logic [1:0] {
        CUT_IGNORE  = 2'd0,
        CUT_HOLD    = 2'd1,
        CUT_ABANDON = 2'd2
    } ipf_cut_e;

endpackage

// File: rtl/ipf_probe.sv
module ipf_probe #(
    parameter int LA_W = 16,
    parameter int NP   = 3
) (
    input  logic [LA_W-1:0]            base,
    input  logic [$clog2(NP+1)-1:0]    depth,
    output logic [NP*LA_W-1:0]         addrs,
    input  logic [NP-1:0]              hit,
    output logic [$clog2(NP+1)-1:0]    run
);
    localparam int RW = $clog2(NP + 1);

    for (genvar g = 0; g < NP; g++) begin : g_lane
        assign addrs[g*LA_W +: LA_W] = base + LA_W'(g + 1);
    end

    logic stop;
    always_comb begin
        run  = '0;
        stop = 1'b0;
        for (int i = 0; i < NP; i++) begin
            if (!stop && (i < int'(depth)) && !hit[i]) begin
                run = run + RW'(1);
            end else begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ipf_cut.sv
module ipf_cut
    import ipf_pkg::*;
#(
    parameter int TW = 3
) (
    input  logic          redirect_valid,
    input  logic          busy,
    input  logic          in_spec,
    input  logic [TW-1:0] rx,
    input  logic [TW-1:0] thresh,
    output ipf_cut_e      cut
);
    always_comb begin
        if (!redirect_valid || !busy) begin
            cut = CUT_IGNORE;
        end else if (in_spec && (rx < thresh)) begin
            cut = CUT_ABANDON;
        end else begin
            cut = CUT_HOLD;
        end
    end
endmodule

// File: rtl/ipf_ctrl.sv
module ipf_ctrl
    import ipf_pkg::*;
#(
    parameter int LA_W   = 16,
    parameter int DW     = 64,
    parameter int BEATS  = IPF_LINE_BEATS,
    parameter int MAX_PF = IPF_MAX_LINES
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [$clog2(MAX_PF+1)-1:0]       cfg_depth,
    input  logic [$clog2(BEATS+1)-1:0]        cfg_thresh,
    input  logic                              miss_valid,
    input  logic [LA_W-1:0]                   miss_addr,
    output logic [MAX_PF*LA_W-1:0]            probe_addr,
    input  logic [MAX_PF-1:0]                 probe_hit,
    input  logic                              redirect_valid,
    input  logic [LA_W-1:0]                   redirect_addr,
    output logic                              bus_req_valid,
    input  logic                              bus_req_ready,
    output logic [LA_W-1:0]                   bus_req_addr,
    output logic [$clog2(MAX_PF+1)-1:0]       bus_req_len,
    output logic                              bus_req_spec,
    output logic                              bus_abort,
    input  logic                              beat_valid,
    input  logic [DW-1:0]                     beat_data,
    output logic                              fill_we,
    output logic [LA_W-1:0]                   fill_line,
    output logic [$clog2(BEATS)-1:0]          fill_idx,
    output logic [DW-1:0]                     fill_data,
    output logic                              line_done_valid,
    output logic [LA_W-1:0]                   line_done_addr
);
    localparam int PFW = $clog2(MAX_PF + 1);
    localparam int CW  = $clog2(BEATS);
    localparam int TW  = $clog2(BEATS + 1);

    ipf_state_e          state_q;
    logic [LA_W-1:0]     base_q;
    logic [PFW-1:0]      spec_q;
    logic [PFW-1:0]      cur_q;
    logic [CW-1:0]       cnt_q;
    logic                pend_v_q;
    logic [LA_W-1:0]     pend_a_q;
    logic                abort_q;
    logic                done_v_q;
    logic [LA_W-1:0]     done_a_q;

    logic [PFW-1:0]      run;
    ipf_cut_e            cut;

    // Probe lanes always look at the lines after the incoming miss address
    ipf_probe #(.LA_W(LA_W), .NP(MAX_PF)) u_probe (
        .base  (miss_addr),
        .depth (cfg_depth),
        .addrs (probe_addr),
        .hit   (probe_hit),
        .run   (run)
    );

    logic            active, acc, complete, last_line, in_spec, busy;
    logic [TW-1:0]   rx;
    logic            hold, pn_v, bound_cut, abandon;
    logic [LA_W-1:0] pn_a, tgt;

    assign busy     = (state_q != S_IDLE);
    assign active   = (state_q == S_SREQ) || (state_q == S_FILL);
    assign acc      = active && beat_valid;
    assign rx       = TW'(cnt_q) + TW'(acc);
    assign complete = acc && (cnt_q == CW'(BEATS - 1));
    assign last_line = (cur_q == spec_q);
    assign in_spec  = active && (cur_q != '0);

    ipf_cut #(.TW(TW)) u_cut (
        .redirect_valid (redirect_valid),
        .busy           (busy),
        .in_spec        (in_spec),
        .rx             (rx),
        .thresh         (cfg_thresh),
        .cut            (cut)
    );

    // A redirect that is not acted on now merges into the pending slot (latest wins)
    assign hold      = (cut == CUT_HOLD);
    assign pn_v      = pend_v_q || hold;
    assign pn_a      = hold ? redirect_addr : pend_a_q;
    // At a line boundary, a pending redirect sees zero received beats
    assign bound_cut = complete && !last_line && pn_v && (cfg_thresh != '0);
    assign abandon   = (cut == CUT_ABANDON) || bound_cut;
    assign tgt       = (cut == CUT_ABANDON) ? redirect_addr : pn_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            base_q   <= '0;
            spec_q   <= '0;
            cur_q    <= '0;
            cnt_q    <= '0;
            pend_v_q <= 1'b0;
            pend_a_q <= '0;
            abort_q  <= 1'b0;
            done_v_q <= 1'b0;
            done_a_q <= '0;
        end else begin
            abort_q  <= 1'b0;
            done_v_q <= complete && (cut != CUT_ABANDON);
            done_a_q <= base_q + LA_W'(cur_q);
            unique case (state_q)
                S_IDLE: begin
                    pend_v_q <= 1'b0;
                    if (miss_valid) begin
                        base_q  <= miss_addr;
                        spec_q  <= run;
                        cur_q   <= '0;
                        cnt_q   <= '0;
                        state_q <= S_DREQ;
                    end
                end
                S_DREQ: begin
                    pend_v_q <= pn_v;
                    pend_a_q <= pn_a;
                    if (bus_req_ready) begin
                        state_q <= (spec_q != '0) ? S_SREQ : S_FILL;
                    end
                end
                S_SREQ, S_FILL: begin
                    if (abandon) begin
                        state_q  <= S_DREQ;
                        base_q   <= tgt;
                        spec_q   <= '0;
                        cur_q    <= '0;
                        cnt_q    <= '0;
                        pend_v_q <= 1'b0;
                        abort_q  <= (state_q == S_FILL);
                    end else begin
                        pend_v_q <= pn_v;
                        pend_a_q <= pn_a;
                        if ((state_q == S_SREQ) && bus_req_ready) begin
                            state_q <= S_FILL;
                        end
                        if (acc) begin
                            if (complete) begin
                                cnt_q <= '0;
                                if (last_line) begin
                                    cur_q    <= '0;
                                    pend_v_q <= 1'b0;
                                    if (pn_v) begin
                                        state_q <= S_DREQ;
                                        base_q  <= pn_a;
                                        spec_q  <= '0;
                                    end else begin
                                        state_q <= S_IDLE;
                                    end
                                end else begin
                                    cur_q <= cur_q + PFW'(1);
                                end
                            end else begin
                                cnt_q <= cnt_q + CW'(1);
                            end
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign bus_req_valid   = (state_q == S_DREQ) || (state_q == S_SREQ);
    assign bus_req_spec    = (state_q == S_SREQ);
    assign bus_req_addr    = bus_req_spec ? (base_q + LA_W'(1)) : base_q;
    assign bus_req_len     = bus_req_spec ? spec_q : PFW'(1);
    assign bus_abort       = abort_q;

    assign fill_we         = acc;
    assign fill_line       = base_q + LA_W'(cur_q);
    assign fill_idx        = cnt_q;
    assign fill_data       = beat_data;

    assign line_done_valid = done_v_q;
    assign line_done_addr  = done_a_q;
endmodule

// File: rtl/ipf_ctrl_chk.sv
module ipf_ctrl_chk #(
    parameter int MAX_PF = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic [$clog2(MAX_PF+1)-1:0] cfg_depth,
    input logic                        bus_req_valid,
    input logic                        bus_req_ready,
    input logic                        bus_req_spec,
    input logic [$clog2(MAX_PF+1)-1:0] bus_req_len,
    input logic                        bus_abort,
    input logic                        line_done_valid
);
    // R3: the burst appears right after a demand handshake
    a_r3_spec_after_demand: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req_spec) |-> $past(bus_req_valid && bus_req_ready && !bus_req_spec));

    // R2: burst length is non-zero and within the configured depth
    a_r2_len_within_depth: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_req_spec) |-> ((bus_req_len != '0) && (bus_req_len <= cfg_depth)));

    // R5: abort comes together with a single-line target demand
    a_r5_abort_with_target: assert property (@(posedge clk) disable iff (rst)
        bus_abort |-> (bus_req_valid && !bus_req_spec && (bus_req_len == 1)));

    // R5: abort is a one-cycle pulse
    a_r5_abort_pulse: assert property (@(posedge clk) disable iff (rst)
        bus_abort |=> !bus_abort);

    // R4: completions are single-cycle pulses
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        line_done_valid |=> !line_done_valid);
endmodule

bind ipf_ctrl ipf_ctrl_chk #(.MAX_PF(MAX_PF)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_depth       (cfg_depth),
    .bus_req_valid   (bus_req_valid),
    .bus_req_ready   (bus_req_ready),
    .bus_req_spec    (bus_req_spec),
    .bus_req_len     (bus_req_len),
    .bus_abort       (bus_abort),
    .line_done_valid (line_done_valid)
);

// File: tb/sim_ipf_ctrl.sv
module sim_ipf_ctrl;
    localparam int LA_W = 16;
    localparam int DW   = 64;
    localparam int NP   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        cfg_depth = '0;
    logic [2:0]        cfg_thresh = '0;
    logic              miss_valid = 1'b0;
    logic [LA_W-1:0]   miss_addr = '0;
    logic [NP*LA_W-1:0] probe_addr;
    logic [NP-1:0]     probe_hit = '0;
    logic              redirect_valid = 1'b0;
    logic [LA_W-1:0]   redirect_addr = '0;
    logic              bus_req_valid;
    logic              bus_req_ready = 1'b1;
    logic [LA_W-1:0]   bus_req_addr;
    logic [1:0]        bus_req_len;
    logic              bus_req_spec;
    logic              bus_abort;
    logic              beat_valid = 1'b0;
    logic [DW-1:0]     beat_data = '0;
    logic              fill_we;
    logic [LA_W-1:0]   fill_line;
    logic [1:0]        fill_idx;
    logic [DW-1:0]     fill_data;
    logic              line_done_valid;
    logic [LA_W-1:0]   line_done_addr;

    always #5 clk = ~clk;

    ipf_ctrl u0 (.*);

    typedef struct packed {
        logic [LA_W-1:0] a;
        logic [1:0]      len;
        logic            spec;
    } req_t;

    req_t            req_q[$];
    logic [LA_W-1:0] done_q[$];
    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int last_dem = -10;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_req_valid && bus_req_ready) begin
                if (req_q.size() == 0) begin
                    check("R3 unexpected request addr", {48'd0, bus_req_addr}, 64'hFFFF_FFFF);
                end else begin
                    req_t e;
                    e = req_q.pop_front();
                    check("R3 request addr", 64'(bus_req_addr), 64'(e.a));
                    check("R3 request len",  64'(bus_req_len),  64'(e.len));
                    check("R3 request spec", 64'(bus_req_spec), 64'(e.spec));
                    if (e.spec) check("R3 burst back-to-back", 64'(cyc), 64'(last_dem + 1));
                    else last_dem = cyc;
                end
            end
            if (line_done_valid) begin
                if (done_q.size() == 0) begin
                    check("R4 unexpected line done", 64'(line_done_addr), 64'hFFFF_FFFF);
                end else begin
                    logic [LA_W-1:0] d;
                    d = done_q.pop_front();
                    check("R4 line done addr", 64'(line_done_addr), 64'(d));
                end
            end
        end
    end

    task automatic go();
        @(posedge clk); #1;
        miss_valid = 1'b0;
        redirect_valid = 1'b0;
        beat_valid = 1'b0;
    endtask

    task automatic mid();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin go(); mid(); end
    endtask

    function automatic int ref_run(input logic [NP-1:0] hits, input int depth);
        int r = 0;
        for (int i = 0; i < NP; i++) begin
            if (i >= depth || hits[i]) return r;
            r++;
        end
        return r;
    endfunction

    // Issues a miss, checks the probe lanes, queues the expected requests, returns the run
    task automatic do_miss(input logic [LA_W-1:0] a, input logic [NP-1:0] hits, output int run);
        run = ref_run(hits, int'(cfg_depth));
        req_q.push_back('{a: a, len: 2'd1, spec: 1'b0});
        if (run > 0) req_q.push_back('{a: a + LA_W'(1), len: 2'(run), spec: 1'b1});
        go();
        miss_valid = 1'b1; miss_addr = a; probe_hit = hits;
        mid();
        for (int i = 0; i < NP; i++)
            check("R1 probe addr", 64'(probe_addr[i*LA_W +: LA_W]), 64'(a + LA_W'(i + 1)));
        idle(2);
    endtask

    task automatic beats(input logic [LA_W-1:0] ln, input int first, input int n);
        for (int k = 0; k < n; k++) begin
            go();
            beat_valid = 1'b1;
            beat_data = {16'hB0A7, 16'(ln), 32'(first + k)};
            mid();
            check("R10 fill we",   64'(fill_we),   64'd1);
            check("R10 fill line", 64'(fill_line), 64'(ln));
            check("R10 fill idx",  64'(fill_idx),  64'(first + k));
            check("R10 fill data", fill_data, {16'hB0A7, 16'(ln), 32'(first + k)});
        end
    endtask

    task automatic redir(input logic [LA_W-1:0] t);
        go();
        redirect_valid = 1'b1; redirect_addr = t;
        mid();
    endtask

    initial begin
        int run;
        logic [LA_W-1:0] a;
        logic [LA_W-1:0] t;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        mid();
        // R11 reset state
        check("R11 req valid", 64'(bus_req_valid), 0);
        check("R11 abort", 64'(bus_abort), 0);
        check("R11 fill we", 64'(fill_we), 0);
        check("R11 line done", 64'(line_done_valid), 0);

        // R1 R3 full prefetch of three lines, R9 miss while busy ignored
        cfg_depth = 2'd3; cfg_thresh = 3'd4;
        a = 16'h0100;
        do_miss(a, 3'b000, run);
        check("R1 run all absent", 64'(run), 3);
        for (int l = 0; l < 4; l++) done_q.push_back(a + LA_W'(l));
        beats(a, 0, 4);
        go(); miss_valid = 1'b1; miss_addr = 16'h7777; mid();
        beats(a + 16'd1, 0, 4);
        beats(a + 16'd2, 0, 4);
        beats(a + 16'd3, 0, 4);
        idle(2);
        check("R9 no request after busy miss", 64'(bus_req_valid), 0);
        check("R4 all done consumed", 64'(done_q.size()), 0);

        // R1 run stops at first present line
        a = 16'h0200;
        do_miss(a, 3'b010, run);
        check("R1 run stops at hit", 64'(run), 1);
        done_q.push_back(a); done_q.push_back(a + 16'd1);
        beats(a, 0, 4); beats(a + 16'd1, 0, 4); idle(2);

        // R2 first line present: demand only
        a = 16'h0300;
        do_miss(a, 3'b001, run);
        check("R2 run zero on first hit", 64'(run), 0);
        done_q.push_back(a);
        beats(a, 0, 4); idle(2);

        // R2 depth limits the run; lane beyond depth ignored
        cfg_depth = 2'd2;
        a = 16'h0400;
        do_miss(a, 3'b100, run);
        check("R2 run limited by depth", 64'(run), 2);
        for (int l = 0; l < 3; l++) done_q.push_back(a + LA_W'(l));
        beats(a, 0, 4); beats(a + 16'd1, 0, 4); beats(a + 16'd2, 0, 4); idle(2);

        // R2 depth zero disables prefetch
        cfg_depth = 2'd0;
        a = 16'h0500;
        do_miss(a, 3'b000, run);
        check("R2 depth zero run", 64'(run), 0);
        done_q.push_back(a);
        beats(a, 0, 4); idle(2);

        // R5 abandon below threshold
        cfg_depth = 2'd3; cfg_thresh = 3'd2;
        a = 16'h0600; t = 16'h0A00;
        do_miss(a, 3'b000, run);
        done_q.push_back(a);
        beats(a, 0, 4);
        beats(a + 16'd1, 0, 1);
        req_q.push_back('{a: t, len: 2'd1, spec: 1'b0});
        redir(t);
        check("R5 no abort in redirect cycle", 64'(bus_abort), 0);
        go(); mid();
        check("R5 abort pulse", 64'(bus_abort), 1);
        check("R5 target request", 64'(bus_req_addr), 64'(t));
        done_q.push_back(t);
        beats(t, 0, 4); idle(2);
        check("R5 abandoned line not reported", 64'(done_q.size()), 0);

        // R6 keep at threshold, R7 cut at the next boundary
        a = 16'h0700; t = 16'h0B00;
        do_miss(a, 3'b000, run);
        done_q.push_back(a); done_q.push_back(a + 16'd1);
        beats(a, 0, 4);
        beats(a + 16'd1, 0, 2);
        redir(t);
        go(); mid();
        check("R6 no abort at threshold", 64'(bus_abort), 0);
        req_q.push_back('{a: t, len: 2'd1, spec: 1'b0});
        beats(a + 16'd1, 2, 2);
        go(); mid();
        check("R7 abort at boundary", 64'(bus_abort), 1);
        done_q.push_back(t);
        beats(t, 0, 4); idle(2);

        // R7 threshold zero never cuts; target served after last line
        cfg_thresh = 3'd0;
        a = 16'h0800; t = 16'h0C00;
        do_miss(a, 3'b000, run);
        for (int l = 0; l < 4; l++) done_q.push_back(a + LA_W'(l));
        beats(a, 0, 4);
        beats(a + 16'd1, 0, 1);
        redir(t);
        go(); mid();
        check("R7 threshold zero keeps", 64'(bus_abort), 0);
        req_q.push_back('{a: t, len: 2'd1, spec: 1'b0});
        beats(a + 16'd1, 1, 3);
        beats(a + 16'd2, 0, 4);
        beats(a + 16'd3, 0, 4);
        go(); mid();
        check("R7 no abort after last line", 64'(bus_abort), 0);
        check("R7 target requested", 64'(bus_req_valid), 1);
        done_q.push_back(t);
        beats(t, 0, 4); idle(2);

        // R8 redirect during demand line is held
        cfg_thresh = 3'd4;
        a = 16'h0900; t = 16'h0D00;
        do_miss(a, 3'b000, run);
        done_q.push_back(a);
        beats(a, 0, 2);
        redir(t);
        go(); mid();
        check("R8 demand not aborted", 64'(bus_abort), 0);
        req_q.push_back('{a: t, len: 2'd1, spec: 1'b0});
        beats(a, 2, 2);
        go(); mid();
        check("R8 cut after demand line", 64'(bus_abort), 1);
        done_q.push_back(t);
        beats(t, 0, 4); idle(2);

        // R9 redirect while idle ignored
        redir(16'h0E00);
        go(); mid();
        check("R9 idle redirect ignored", 64'(bus_req_valid), 0);
        idle(2);

        check("R3 leftover requests", 64'(req_q.size()), 0);
        check("R4 leftover completions", 64'(done_q.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule